// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block produces the reset for a small 8-bit processor core. Four events can put the core into reset: a low level on the shared board reset pin, an instruction fetch from the data region at the bottom of the address map, an overflow pulse from the watchdog counter, and a clock configuration in which both oscillators are switched off. A pin event is accepted only after the pin has stayed low long enough to rule out a glitch. Each fault detected on chip is stretched into a long reset pulse that the block also puts on the board pin by pulling it low. The pin is open-drain and is otherwise released.

The core leaves reset only when the stretch interval has ended and the pin reads high again. Release happens in a single cycle that carries a vector-fetch strobe. On that strobe the core loads its start address from the vector at the top of its address space. A four-bit one-hot register keeps the cause of the most recent reset, so that firmware can tell after start-up why it restarted.

Top module: `sys_reset_ctrl`

## Requirements
- R1: After power-on reset (`porRstN` low), the outputs are `coreRst`=0, `pinDriveLow`=0 and `vecFetch`=0, and `lastCause`=4'b0000.
- R2: A pin reset is accepted only after the pin has read low for LOW_MIN consecutive clocks (default 12). A pin pulse that is low for 11 clocks has no effect on `coreRst` or on `lastCause`.
- R3: While a pin reset is accepted, `coreRst` stays 1 for as long as the pin is held low, and `pinDriveLow` stays 0. The cause is recorded as external, which is bit 0 (4'b0001).
- R4: A fetch strobe (`fetchValid`=1) with an address from 0x0000 to 0x083F inclusive starts an internal reset and records cause bit 1 (4'b0010). A fetch from 0x0840 or above does not start a reset. An address with `fetchValid`=0 does not start a reset either.
- R5: A `wdtOverflow` pulse starts an internal reset and records cause bit 2 (4'b0100).
- R6: The condition `hfOscEn`=0 and `lfOscEn`=0 at the same time starts an internal reset and records cause bit 3 (4'b1000). The reset does not start while either enable is 1.
- R7: After a single internal fault, `pinDriveLow` is 1 for exactly STRETCH_CLKS clocks, starting the clock after the fault is sampled. `coreRst` is 1 throughout that interval.
- R8: A fault that arrives while the stretch is running restarts the stretch from zero, and the cause is replaced by the new fault. A second fault k clocks after the first gives k+STRETCH_CLKS driven clocks.
- R9: When faults arrive in the same clock, the recorded cause follows this priority: address trap, then watchdog, then clock deadlock.
- R10: Release waits until the stretch has ended and the synchronized pin reads high. The release cycle, which is the first cycle with `coreRst`=0, carries a one-cycle `vecFetch` pulse. The pin passes through a two-flop synchronizer, so `coreRst` falls at the third clock edge after the pin goes high.
- R11: `lastCause` keeps its value until the next reset event. Release does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| pinIn | input | 1 | Level read back from the open-drain reset pin |
| fetchValid | input | 1 | Instruction-fetch strobe from the core |
| fetchAddr | input | ADDR_W | Address of the current instruction fetch |
| wdtOverflow | input | 1 | Overflow pulse from the watchdog counter |
| hfOscEn | input | 1 | High-frequency oscillator enable bit |
| lfOscEn | input | 1 | Low-frequency oscillator enable bit |
| pinDriveLow | output | 1 | 1 pulls the reset pin low, 0 releases it |
| coreRst | output | 1 | Reset to the core, active high |
| vecFetch | output | 1 | One-cycle strobe at release telling the core to load its reset vector |
| lastCause | output | 4 | One-hot cause of the last reset: bit0 pin, bit1 trap, bit2 watchdog, bit3 clock |

## Verification
The bench goes after the edge of the glitch filter with an 11-clock pulse and a 12-clock pulse. A filter that is off by one would accept the glitch or drop the valid pulse. It checks the address trap on both sides of 0x083F/0x0840, where a wrong comparison either misses a fetch from the data region or resets on legal code. It measures the length of the drive on the pin for a single fault and for a fault that retriggers the stretch, where a counter that does not restart would release too early. It holds the pin low past the end of a stretch and checks the release timing. A controller that ignored the pin read-back would then let the core run while the board still holds it in reset.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_STRETCH = 2'd1,
    ST_HOLD    = 2'd2
  } rstState_t;

  typedef struct packed {
    logic       stretchClr;
    logic       stretchRun;
    logic       causeLoad;
    logic [3:0] causeVal;
  } dpCtl_t;

  localparam logic [3:0] CAUSE_EXT  = 4'b0001;
  localparam logic [3:0] CAUSE_TRAP = 4'b0010;
  localparam logic [3:0] CAUSE_WDT  = 4'b0100;
  localparam logic [3:0] CAUSE_CLK  = 4'b1000;

endpackage

// File: rtl/sysrst_datapath.sv
module sysrst_datapath
  import sysrst_pkg::*;
#(
  parameter int          LOW_MIN      = 12,
  parameter int          STRETCH_CLKS = 1 << 20,
  parameter int          ADDR_W       = 16,
  parameter int unsigned TRAP_HI      = 'h083F
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              pinIn,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              wdtOverflow,
  input  logic              hfOscEn,
  input  logic              lfOscEn,
  input  dpCtl_t            ctl,
  output logic              pinHigh,
  output logic              extLow,
  output logic              faultAny,
  output logic [3:0]        faultCause,
  output logic              stretchDone,
  output logic [3:0]        lastCause
);

  localparam int LW = $clog2(LOW_MIN + 1);
  localparam int CW = $clog2(STRETCH_CLKS);

  logic [1:0]    syncQ;
  logic [LW-1:0] lowCnt;
  logic [CW-1:0] stretchCnt;
  logic          trapHit;
  logic          clkDead;

  // two-flop synchronizer for the pin read-back, idles high
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) syncQ <= 2'b11;
    else          syncQ <= {syncQ[0], pinIn};
  end
  assign pinHigh = syncQ[1];

  // low-time filter: counts consecutive low samples, saturates at LOW_MIN
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                     lowCnt <= '0;
    else if (pinHigh)                 lowCnt <= '0;
    else if (lowCnt != LW'(LOW_MIN))  lowCnt <= lowCnt + 1'b1;
  end
  assign extLow = (lowCnt == LW'(LOW_MIN));

  // fault detection with fixed priority trap > watchdog > clock
  assign trapHit  = fetchValid && (fetchAddr <= ADDR_W'(TRAP_HI));
  assign clkDead  = !hfOscEn && !lfOscEn;
  assign faultAny = trapHit || wdtOverflow || clkDead;

  always_comb begin
    if (trapHit)          faultCause = CAUSE_TRAP;
    else if (wdtOverflow) faultCause = CAUSE_WDT;
    else if (clkDead)     faultCause = CAUSE_CLK;
    else                  faultCause = 4'b0000;
  end

  // stretch timer
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                          stretchCnt <= '0;
    else if (ctl.stretchClr)               stretchCnt <= '0;
    else if (ctl.stretchRun && !stretchDone) stretchCnt <= stretchCnt + 1'b1;
  end
  assign stretchDone = (stretchCnt == CW'(STRETCH_CLKS - 1));

  // cause register
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)           lastCause <= 4'b0000;
    else if (ctl.causeLoad) lastCause <= ctl.causeVal;
  end

  p_filter_bound_r2: assert property (@(posedge clk) disable iff (!porRstN)
    lowCnt <= LW'(LOW_MIN));

  p_stretch_bound_r7: assert property (@(posedge clk) disable iff (!porRstN)
    stretchCnt <= CW'(STRETCH_CLKS - 1));

  p_cause_hold_r11: assert property (@(posedge clk) disable iff (!porRstN)
    !ctl.causeLoad |=> $stable(lastCause));

  p_cause_onehot_r9: assert property (@(posedge clk) disable iff (!porRstN)
    $onehot0(lastCause));

endmodule

// File: rtl/sysrst_control.sv
module sysrst_control
  import sysrst_pkg::*;
(
  input  logic       clk,
  input  logic       porRstN,
  input  logic       pinHigh,
  input  logic       extLow,
  input  logic       faultAny,
  input  logic [3:0] faultCause,
  input  logic       stretchDone,
  output dpCtl_t     ctl,
  output logic       coreRst,
  output logic       pinDriveLow,
  output logic       vecFetch
);

  rstState_t state, stateNext;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    if (faultAny) begin
      stateNext      = ST_STRETCH;
      ctl.stretchClr = 1'b1;
      ctl.causeLoad  = 1'b1;
      ctl.causeVal   = faultCause;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (extLow) begin
            stateNext     = ST_HOLD;
            ctl.causeLoad = 1'b1;
            ctl.causeVal  = CAUSE_EXT;
          end
        end
        ST_STRETCH: begin
          ctl.stretchRun = 1'b1;
          if (stretchDone) stateNext = ST_HOLD;
        end
        ST_HOLD: begin
          if (pinHigh) stateNext = ST_RUN;
        end
        default: stateNext = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      state    <= ST_RUN;
      vecFetch <= 1'b0;
    end else begin
      state    <= stateNext;
      vecFetch <= (state == ST_HOLD) && (stateNext == ST_RUN);
    end
  end

  assign coreRst     = (state != ST_RUN);
  assign pinDriveLow = (state == ST_STRETCH);

  p_drive_in_reset_r7: assert property (@(posedge clk) disable iff (!porRstN)
    pinDriveLow |-> coreRst);

  p_fault_drives_r8: assert property (@(posedge clk) disable iff (!porRstN)
    faultAny |=> pinDriveLow);

  p_vec_single_r10: assert property (@(posedge clk) disable iff (!porRstN)
    vecFetch |=> !vecFetch);

  p_release_pin_r10: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(coreRst) |-> ($past(pinHigh) && vecFetch));

endmodule

// File: rtl/sys_reset_ctrl.sv
module sys_reset_ctrl
  import sysrst_pkg::*;
#(
  parameter int          LOW_MIN      = 12,
  parameter int          STRETCH_CLKS = 1 << 20,
  parameter int          ADDR_W       = 16,
  parameter int unsigned TRAP_HI      = 'h083F
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              pinIn,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              wdtOverflow,
  input  logic              hfOscEn,
  input  logic              lfOscEn,
  output logic              pinDriveLow,
  output logic              coreRst,
  output logic              vecFetch,
  output logic [3:0]        lastCause
);

  dpCtl_t     ctl;
  logic       pinHigh;
  logic       extLow;
  logic       faultAny;
  logic [3:0] faultCause;
  logic       stretchDone;

  sysrst_datapath #(
    .LOW_MIN     (LOW_MIN),
    .STRETCH_CLKS(STRETCH_CLKS),
    .ADDR_W      (ADDR_W),
    .TRAP_HI     (TRAP_HI)
  ) u_datapath (
    .clk        (clk),
    .porRstN    (porRstN),
    .pinIn      (pinIn),
    .fetchValid (fetchValid),
    .fetchAddr  (fetchAddr),
    .wdtOverflow(wdtOverflow),
    .hfOscEn    (hfOscEn),
    .lfOscEn    (lfOscEn),
    .ctl        (ctl),
    .pinHigh    (pinHigh),
    .extLow     (extLow),
    .faultAny   (faultAny),
    .faultCause (faultCause),
    .stretchDone(stretchDone),
    .lastCause  (lastCause)
  );

  sysrst_control u_control (
    .clk        (clk),
    .porRstN    (porRstN),
    .pinHigh    (pinHigh),
    .extLow     (extLow),
    .faultAny   (faultAny),
    .faultCause (faultCause),
    .stretchDone(stretchDone),
    .ctl        (ctl),
    .coreRst    (coreRst),
    .pinDriveLow(pinDriveLow),
    .vecFetch   (vecFetch)
  );

  p_trap_resets_r4: assert property (@(posedge clk) disable iff (!porRstN)
    (fetchValid && (fetchAddr <= ADDR_W'(TRAP_HI))) |=> (coreRst && pinDriveLow));

  p_clock_dead_r6: assert property (@(posedge clk) disable iff (!porRstN)
    (!hfOscEn && !lfOscEn) |=> pinDriveLow);

endmodule

// File: tb/sys_reset_ctrl_bench.sv
module sys_reset_ctrl_bench;

  localparam int N    = 40;
  localparam int LMIN = 12;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        extDrive = 1'b0;
  logic        pinIn;
  logic        fetchValid = 1'b0;
  logic [15:0] fetchAddr = 16'h0000;
  logic        wdtOverflow = 1'b0;
  logic        hfOscEn = 1'b1;
  logic        lfOscEn = 1'b1;
  logic        pinDriveLow, coreRst, vecFetch;
  logic [3:0]  lastCause;

  always #2 clk = ~clk;

  // wired-AND model of the open-drain pin with pull-up
  assign pinIn = !(extDrive || pinDriveLow);

  sys_reset_ctrl #(.LOW_MIN(LMIN), .STRETCH_CLKS(N)) u_sys_reset_ctrl (
    .clk(clk), .porRstN(porRstN), .pinIn(pinIn), .fetchValid(fetchValid),
    .fetchAddr(fetchAddr), .wdtOverflow(wdtOverflow), .hfOscEn(hfOscEn),
    .lfOscEn(lfOscEn), .pinDriveLow(pinDriveLow), .coreRst(coreRst),
    .vecFetch(vecFetch), .lastCause(lastCause)
  );

  typedef struct {
    string      req;
    logic [3:0] cause;
    int         drive;
  } expItem_t;

  expItem_t expQ[$];
  int compared   = 0;
  int mismatched = 0;
  int driveCnt   = 0;
  logic prevVec  = 1'b0;
  bit finished   = 1'b0;

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_reset(string req, logic [3:0] cause, int drive);
    expItem_t it;
    it.req = req; it.cause = cause; it.drive = drive;
    expQ.push_back(it);
  endtask

  // monitor: measures each reset episode and compares at its release strobe
  always @(negedge clk) begin
    if (!porRstN) begin
      driveCnt = 0;
      prevVec  = 1'b0;
    end else begin
      if (pinDriveLow) driveCnt++;
      if (vecFetch && prevVec) check("R10", "vecFetch width", 2, 1);
      if (vecFetch && !prevVec) begin
        if (expQ.size() == 0) begin
          check("R10", "unexpected release", 1, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(it.req, "cause", int'(lastCause), int'(it.cause));
          check(it.req, "driven clocks", driveCnt, it.drive);
          check("R10", "coreRst at vecFetch", int'(coreRst), 0);
        end
        driveCnt = 0;
      end
      prevVec = vecFetch;
    end
  end

  // all tasks start and end on a negedge
  task automatic pin_low(int len);
    extDrive = 1'b1;
    repeat (len) @(negedge clk);
    extDrive = 1'b0;
  endtask

  task automatic fetch_pulse(logic [15:0] a);
    fetchValid = 1'b1; fetchAddr = a;
    @(negedge clk);
    fetchValid = 1'b0; fetchAddr = 16'hFFFE;
  endtask

  task automatic wdt_pulse();
    wdtOverflow = 1'b1;
    @(negedge clk);
    wdtOverflow = 1'b0;
  endtask

  task automatic clk_dead_pulse();
    hfOscEn = 1'b0; lfOscEn = 1'b0;
    @(negedge clk);
    hfOscEn = 1'b1; lfOscEn = 1'b1;
  endtask

  task automatic wait_release();
    while (coreRst) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    porRstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "coreRst", int'(coreRst), 0);
    check("R1", "pinDriveLow", int'(pinDriveLow), 0);
    check("R1", "vecFetch", int'(vecFetch), 0);
    check("R1", "lastCause", int'(lastCause), 0);

    // R2 glitch of 11 clocks is ignored
    pin_low(LMIN - 1);
    repeat (8) @(negedge clk);
    check("R2", "coreRst after short pulse", int'(coreRst), 0);
    check("R2", "lastCause after short pulse", int'(lastCause), 0);

    // R2 a 12-clock pulse is accepted
    expect_reset("R2", 4'b0001, 0);
    pin_low(LMIN);
    repeat (8) @(negedge clk);
    check("R2", "lastCause after 12-clock pulse", int'(lastCause), 1);

    // R3 long pin hold keeps the core in reset without driving
    expect_reset("R3", 4'b0001, 0);
    extDrive = 1'b1;
    repeat (40) @(negedge clk);
    check("R3", "coreRst while pin low", int'(coreRst), 1);
    check("R3", "pinDriveLow while pin low", int'(pinDriveLow), 0);
    extDrive = 1'b0;
    wait_release();

    // R4 address trap boundary
    expect_reset("R4", 4'b0010, N);
    fetch_pulse(16'h083F);
    check("R4", "coreRst after 0x083F", int'(coreRst), 1);
    check("R7", "pinDriveLow after trap", int'(pinDriveLow), 1);
    wait_release();
    fetch_pulse(16'h0840);
    repeat (3) @(negedge clk);
    check("R4", "coreRst after 0x0840", int'(coreRst), 0);
    fetchAddr = 16'h0000;
    repeat (3) @(negedge clk);
    check("R4", "coreRst with no strobe", int'(coreRst), 0);
    fetchAddr = 16'hFFFE;

    // R5 watchdog
    expect_reset("R5", 4'b0100, N);
    wdt_pulse();
    check("R5", "coreRst after overflow", int'(coreRst), 1);
    wait_release();

    // R6 one oscillator still enabled: no reset
    hfOscEn = 1'b0;
    repeat (4) @(negedge clk);
    hfOscEn = 1'b1; lfOscEn = 1'b0;
    repeat (4) @(negedge clk);
    lfOscEn = 1'b1;
    repeat (2) @(negedge clk);
    check("R6", "coreRst with one oscillator on", int'(coreRst), 0);
    expect_reset("R6", 4'b1000, N);
    clk_dead_pulse();
    check("R6", "coreRst after deadlock", int'(coreRst), 1);
    wait_release();

    // R8 retrigger: trap then watchdog 11 clocks later
    expect_reset("R8", 4'b0100, 11 + N);
    fetch_pulse(16'h0100);
    repeat (10) @(negedge clk);
    wdt_pulse();
    wait_release();

    // R9 simultaneous faults
    expect_reset("R9", 4'b0010, N);
    wdtOverflow = 1'b1;
    fetch_pulse(16'h0000);
    wdtOverflow = 1'b0;
    wait_release();
    expect_reset("R9", 4'b0100, N);
    hfOscEn = 1'b0; lfOscEn = 1'b0;
    wdt_pulse();
    hfOscEn = 1'b1; lfOscEn = 1'b1;
    wait_release();

    // R11 cause persists while idle
    repeat (20) @(negedge clk);
    check("R11", "lastCause held", int'(lastCause), 4);

    // R10 pin held low beyond the stretch delays release
    expect_reset("R10", 4'b1000, N);
    clk_dead_pulse();
    extDrive = 1'b1;
    repeat (N + 10) @(negedge clk);
    check("R10", "coreRst while pin held", int'(coreRst), 1);
    check("R10", "pinDriveLow after stretch", int'(pinDriveLow), 0);
    extDrive = 1'b0;
    repeat (2) @(negedge clk);
    check("R10", "coreRst two clocks after pin high", int'(coreRst), 1);
    @(negedge clk);
    check("R10", "coreRst three clocks after pin high", int'(coreRst), 0);
    check("R10", "vecFetch at release", int'(vecFetch), 1);
    repeat (4) @(negedge clk);

    check("R10", "pending releases", expQ.size(), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule